// File: doc/BRIEF.md
# Autopoll Device Address Selector

This block decides which device on a serial peripheral bus should be polled next. It then forms the Talk-register-0 command byte for that device. A host controller strobes a request while the bus is idle and supplies four inputs: the set of device addresses enrolled for automatic polling, the poll command issued most recently, the command byte actually sent last, and a flag that records a pending service request from some device. One cycle later the block returns either a command byte to issue or an indication that no new command is needed.

The block keeps polling the same device while that device is still enrolled and no other device is asking for service. It moves on only when a service request arrived while the last transmitted command was the poll itself, or when the current device was removed from the set. Moving on picks the next enrolled address above the current one, and wraps around to the lowest enrolled address when none lies above. A command identical to the last one sent is not issued again, because the bus transceiver already repeats that command on its own while idle.

Top module: `autopoll_pick`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `valid_o` and `no_poll_o` are 0 and `poll_cmd_o` is 0.
- R2: `valid_o` is 1 in exactly the cycle after a cycle in which `req_i` was 1, and 0 otherwise; back-to-back requests give back-to-back results.
- R3: Bit 0 of `dev_mask_i` is treated as 0, so address 0 is never polled. A mask holding only bit 0 counts as empty, and a current address of 0 always moves on.
- R4: When the effective mask is empty, the result has `no_poll_o` = 1 and `poll_cmd_o` = 0.
- R5: The current address is bits 7:4 of `last_poll_cmd_i`. It is kept when its mask bit is set and it is not true that `srq_i` = 1 with `last_cmd_i` equal to `last_poll_cmd_i`.
- R6: When `srq_i` = 1 and `last_cmd_i` equals `last_poll_cmd_i`, the selection moves on from the current address.
- R7: When the current address's mask bit is 0, the selection moves on.
- R8: Moving on selects the lowest set mask bit strictly above the current address. If none exists, it selects the lowest set bit of the whole mask.
- R9: An issued command has the selected address in bits 7:4, the Talk opcode 2'b11 in bits 3:2 and register 2'b00 in bits 1:0, so its low nibble is 4'hC.
- R10: When the formed command equals `last_cmd_i`, the result has `no_poll_o` = 1 and `poll_cmd_o` = 0.
- R11: Inputs are sampled only on `req_i`. Between requests, `poll_cmd_o` and `no_poll_o` hold the last result whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Evaluate the selection on this cycle's inputs |
| dev_mask_i | input | 16 | Enrolled device addresses, bit n = address n |
| last_poll_cmd_i | input | 8 | Poll command issued most recently |
| last_cmd_i | input | 8 | Command byte transmitted most recently |
| srq_i | input | 1 | A service request was seen |
| valid_o | output | 1 | Result strobe, one cycle after `req_i` |
| no_poll_o | output | 1 | No new command is needed |
| poll_cmd_o | output | 8 | Poll command byte to issue |

## Verification
The bench targets the wrap-around case in two forms: with no enrolled address above the current one, and with a single enrolled device whose service request leads the search back to itself. A search that fails to wrap returns no device or a stale address. A block that skips the repeat check reissues the command the transceiver is already repeating. Address 0 is exercised both as the only mask bit and as the current address, which catches a design that forgets to clear bit 0 and polls the reserved address. The bench also pairs a service request with a mismatching last command, where a design that tests only the flag would wrongly leave a still-enrolled device. A sweep over every single-device mask checks the address field and the opcode bits at each position.

// File: rtl/apsel_pkg.sv
// Package apsel_pkg
// Shared constants for the autopoll address selector.
// Assumes a command byte made of an address field above a 4-bit op/register field.
package apsel_pkg;
    localparam int unsigned APSEL_ADDR_W = 4;
    localparam int unsigned APSEL_OPREG_W = 4;
    // Talk opcode 2'b11 in the upper pair, register 0 in the lower pair
    localparam logic [APSEL_OPREG_W-1:0] APSEL_TALK_R0 = 4'b1100;
endpackage

// File: rtl/apsel_mask_clean.sv
// Module apsel_mask_clean
// Removes address 0 from the enrolled set and reports whether any device remains.
// Assumes bit n of the mask stands for device address n.
module apsel_mask_clean #(
    parameter int unsigned NDEV = 16
) (
    input  logic [NDEV-1:0] mask_i,
    output logic [NDEV-1:0] mask_o,
    output logic            any_o
);
    // Force the reserved address out of the set
    always_comb begin
        mask_o    = mask_i;
        mask_o[0] = 1'b0;
        any_o     = |mask_o;
    end
endmodule

// File: rtl/apsel_next_pick.sv
// Module apsel_next_pick
// Keeps the current address or, when asked to move, finds the next enrolled
// address above it and wraps to the lowest enrolled one.
// Assumes the mask is already cleaned; the output address is meaningless for an empty mask.
module apsel_next_pick #(
    parameter int unsigned ADDR_W = 4,
    localparam int unsigned NDEV = 1 << ADDR_W
) (
    input  logic [NDEV-1:0]   mask_i,
    input  logic [ADDR_W-1:0] cand_i,
    input  logic              srq_move_i,
    output logic [ADDR_W-1:0] addr_o
);
    logic [NDEV-1:0]   above;
    logic [ADDR_W-1:0] hi_idx;
    logic              hi_any;
    logic [ADDR_W-1:0] lo_idx;
    logic              move;

    // Mark enrolled addresses strictly above the candidate
    genvar g;
    generate
        for (g = 0; g < NDEV; g++) begin : g_above
            assign above[g] = mask_i[g] && (ADDR_W'(g) > cand_i);
        end
    endgenerate

    // Lowest set bit above the candidate, and lowest set bit overall
    always_comb begin
        hi_idx = '0;
        hi_any = 1'b0;
        lo_idx = '0;
        for (int i = NDEV - 1; i >= 0; i--) begin
            if (above[i]) begin
                hi_idx = ADDR_W'(i);
                hi_any = 1'b1;
            end
            if (mask_i[i]) begin
                lo_idx = ADDR_W'(i);
            end
        end
    end

    // Choose between staying on the candidate and moving on
    always_comb begin
        move   = srq_move_i || !mask_i[cand_i];
        addr_o = cand_i;
        if (move) begin
            addr_o = hi_any ? hi_idx : lo_idx;
        end
    end
endmodule

// File: rtl/apsel_cmd_form.sv
// Module apsel_cmd_form
// Builds the Talk-register-0 byte and suppresses it when there is nothing to
// poll or when it matches the command the transceiver already repeats.
// Assumes a suppressed result carries an all-zero command.
module apsel_cmd_form
    import apsel_pkg::*;
#(
    parameter int unsigned ADDR_W = 4,
    localparam int unsigned CMD_W = ADDR_W + APSEL_OPREG_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              any_i,
    input  logic [CMD_W-1:0]  last_cmd_i,
    output logic [CMD_W-1:0]  cmd_o,
    output logic              no_poll_o
);
    logic [CMD_W-1:0] formed;

    // Assemble the command and apply both suppression rules
    always_comb begin
        formed    = {addr_i, APSEL_TALK_R0};
        no_poll_o = !any_i || (formed == last_cmd_i);
        cmd_o     = no_poll_o ? '0 : formed;
    end
endmodule

// File: rtl/autopoll_pick.sv
// Module autopoll_pick
// Top of the autopoll selector: samples its inputs on req_i, runs the
// combinational search and registers the result for one-cycle delivery.
// Assumes req_i is only raised while the bus is idle; results hold between requests.
module autopoll_pick
    import apsel_pkg::*;
#(
    parameter int unsigned ADDR_W = APSEL_ADDR_W,
    localparam int unsigned NDEV  = 1 << ADDR_W,
    localparam int unsigned CMD_W = ADDR_W + APSEL_OPREG_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [NDEV-1:0]  dev_mask_i,
    input  logic [CMD_W-1:0] last_poll_cmd_i,
    input  logic [CMD_W-1:0] last_cmd_i,
    input  logic             srq_i,
    output logic             valid_o,
    output logic             no_poll_o,
    output logic [CMD_W-1:0] poll_cmd_o
);
    logic [NDEV-1:0]   clean_mask;
    logic              mask_any;
    logic [ADDR_W-1:0] cand;
    logic              srq_move;
    logic [ADDR_W-1:0] pick_addr;
    logic [CMD_W-1:0]  next_cmd;
    logic              next_no_poll;

    // Candidate address and the service-request move condition
    always_comb begin
        cand     = last_poll_cmd_i[CMD_W-1 -: ADDR_W];
        srq_move = srq_i && (last_cmd_i == last_poll_cmd_i);
    end

    apsel_mask_clean #(.NDEV(NDEV)) u_clean (
        .mask_i (dev_mask_i),
        .mask_o (clean_mask),
        .any_o  (mask_any)
    );

    apsel_next_pick #(.ADDR_W(ADDR_W)) u_pick (
        .mask_i     (clean_mask),
        .cand_i     (cand),
        .srq_move_i (srq_move),
        .addr_o     (pick_addr)
    );

    apsel_cmd_form #(.ADDR_W(ADDR_W)) u_form (
        .addr_i     (pick_addr),
        .any_i      (mask_any),
        .last_cmd_i (last_cmd_i),
        .cmd_o      (next_cmd),
        .no_poll_o  (next_no_poll)
    );

    // Result register: capture on request, pulse valid, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o    <= 1'b0;
            no_poll_o  <= 1'b0;
            poll_cmd_o <= '0;
        end else begin
            valid_o <= req_i;
            if (req_i) begin
                no_poll_o  <= next_no_poll;
                poll_cmd_o <= next_cmd;
            end
        end
    end
endmodule

// File: rtl/autopoll_pick_chk.sv
// Module autopoll_pick_chk
// Property checker bound to autopoll_pick; observes ports only.
// Assumes synchronous active-low reset.
module autopoll_pick_chk #(
    parameter int unsigned ADDR_W = 4,
    localparam int unsigned NDEV  = 1 << ADDR_W,
    localparam int unsigned CMD_W = ADDR_W + 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_i,
    input logic [NDEV-1:0]  dev_mask_i,
    input logic [CMD_W-1:0] last_cmd_i,
    input logic             valid_o,
    input logic             no_poll_o,
    input logic [CMD_W-1:0] poll_cmd_o
);
    logic [NDEV-1:0]  mask_q;
    logic [CMD_W-1:0] last_q;

    // Keep the inputs of the most recent request for comparison
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            last_q <= '0;
        end else if (req_i) begin
            mask_q <= dev_mask_i;
            last_q <= last_cmd_i;
        end
    end

    // R2
    valid_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);
    // R2
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o);
    // R4
    suppressed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && no_poll_o) |-> (poll_cmd_o == '0));
    // R9
    talk_format_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !no_poll_o) |-> (poll_cmd_o[3:0] == 4'hC));
    // R3
    enrolled_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !no_poll_o) |->
            (poll_cmd_o[CMD_W-1 -: ADDR_W] != '0) && mask_q[poll_cmd_o[CMD_W-1 -: ADDR_W]]);
    // R10
    no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !no_poll_o) |-> (poll_cmd_o != last_q));
    // R11
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ($stable(poll_cmd_o) && $stable(no_poll_o)));
endmodule

bind autopoll_pick autopoll_pick_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .dev_mask_i (dev_mask_i),
    .last_cmd_i (last_cmd_i),
    .valid_o    (valid_o),
    .no_poll_o  (no_poll_o),
    .poll_cmd_o (poll_cmd_o)
);

// File: tb/autopoll_pick_tb.sv
module autopoll_pick_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [15:0] dev_mask_i = '0;
    logic [7:0]  last_poll_cmd_i = '0;
    logic [7:0]  last_cmd_i = '0;
    logic        srq_i = 1'b0;
    logic        valid_o;
    logic        no_poll_o;
    logic [7:0]  poll_cmd_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [8:0] exp_q[$];
    string      tag_q[$];
    logic       done = 1'b0;

    always #10 clk = ~clk;

    autopoll_pick u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .dev_mask_i(dev_mask_i),
        .last_poll_cmd_i(last_poll_cmd_i), .last_cmd_i(last_cmd_i), .srq_i(srq_i),
        .valid_o(valid_o), .no_poll_o(no_poll_o), .poll_cmd_o(poll_cmd_o)
    );

    // Reference model written from the requirements: {no_poll, cmd}
    function automatic logic [8:0] model(input logic [15:0] mask, input logic [7:0] lpc,
                                         input logic [7:0] lc, input logic srq);
        logic [15:0] m;
        logic [3:0]  a;
        logic        found;
        logic [7:0]  cmd;
        m = mask & 16'hFFFE;
        if (m == 16'h0) return {1'b1, 8'h00};
        a = lpc[7:4];
        if ((srq && lc == lpc) || !m[a]) begin
            found = 1'b0;
            for (int i = 0; i < 16; i++)
                if (!found && i > int'(a) && m[i]) begin a = 4'(i); found = 1'b1; end
            for (int i = 0; i < 16; i++)
                if (!found && m[i]) begin a = 4'(i); found = 1'b1; end
        end
        cmd = {a, 4'hC};
        if (cmd == lc) return {1'b1, 8'h00};
        return {1'b0, cmd};
    endfunction

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual no_poll=%0b cmd=%h expected no_poll=%0b cmd=%h",
                     tag, act[8], act[7:0], exp[8], exp[7:0]);
        end
    endtask

    // Driver: set inputs, push expectation, raise req for one cycle
    task automatic put(input string tag, input logic [15:0] m, input logic [7:0] lpc,
                       input logic [7:0] lc, input logic s, input logic hold);
        @(negedge clk);
        dev_mask_i = m; last_poll_cmd_i = lpc; last_cmd_i = lc; srq_i = s;
        req_i = 1'b1;
        exp_q.push_back(model(m, lpc, lc, s));
        tag_q.push_back(tag);
        if (!hold) begin
            @(negedge clk);
            req_i = 1'b0;
        end
    endtask

    // Monitor: compare each result as it appears
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (exp_q.size() == 0) begin
                n_tests++; n_fail++;
                $display("FAIL R2: actual valid=1 expected valid=0");
            end else begin
                check(tag_q.pop_front(), {no_poll_o, poll_cmd_o}, exp_q.pop_front());
            end
        end
    end

    initial begin
        #3_000_000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] held;
        repeat (3) @(negedge clk);
        check("R1 in reset", {valid_o, poll_cmd_o}, 9'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {valid_o | no_poll_o, poll_cmd_o}, 9'h0);

        put("R5 stay", 16'h0004, 8'h2C, 8'h00, 1'b0, 1'b0);
        put("R4 empty", 16'h0000, 8'h2C, 8'h00, 1'b0, 1'b0);
        put("R3 only bit0", 16'h0001, 8'h0C, 8'h00, 1'b0, 1'b0);
        put("R6 srq move", 16'h0028, 8'h3C, 8'h3C, 1'b1, 1'b0);
        put("R5 srq other cmd", 16'h0028, 8'h3C, 8'h2C, 1'b1, 1'b0);
        put("R7 removed", 16'h0090, 8'h5C, 8'h00, 1'b0, 1'b0);
        put("R8 wrap removed", 16'h0006, 8'hFC, 8'h00, 1'b0, 1'b0);
        put("R8 wrap srq", 16'h0404, 8'hAC, 8'hAC, 1'b1, 1'b0);
        put("R10 repeat", 16'h0008, 8'h3C, 8'h3C, 1'b0, 1'b0);
        put("R10 single srq", 16'h0008, 8'h3C, 8'h3C, 1'b1, 1'b0);
        put("R3 cand zero", 16'h0003, 8'h0C, 8'h00, 1'b0, 1'b0);
        put("R9 top addr", 16'h8000, 8'h1C, 8'h00, 1'b0, 1'b0);
        // R2 back-to-back requests
        put("R2 burst a", 16'h0030, 8'h4C, 8'h00, 1'b0, 1'b1);
        put("R2 burst b", 16'h0030, 8'h5C, 8'h5C, 1'b1, 1'b0);
        for (int a = 1; a < 16; a++)
            put("R9 sweep", 16'(1 << a), 8'h0C, 8'h00, 1'b0, 1'b0);

        // R11: change inputs without a request, result must hold
        put("R11 setup", 16'h0040, 8'h6C, 8'h00, 1'b0, 1'b0);
        @(negedge clk);
        held = poll_cmd_o;
        dev_mask_i = 16'h0100; last_poll_cmd_i = 8'h1C; last_cmd_i = 8'h6C; srq_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R11 hold", {no_poll_o, poll_cmd_o}, {1'b0, held});
        check("R2 idle valid", {8'h0, valid_o}, 9'h0);
        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_tests++; n_fail++;
            $display("FAIL R2: actual %0d results missing expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule